// File: doc/BRIEF.md
# Variable-Length Key Schedule Sequencer

This block rebuilds the working tables of a 16-round Feistel block cipher whenever a new key arrives. It holds the 18-entry subkey array and four key-dependent lookup tables. It also holds the single-round engine that uses them. The lookup tables have 2^IDX_W entries each, and the standard build uses IDX_W = 8. Before each key change, the surrounding logic writes the standard starting constants into the tables through a word-wide preload port.

When a key is accepted, the sequencer folds the key words cyclically into the subkeys. The length of the key in 32-bit words is chosen at run time. The sequencer then encrypts a 64-bit running value over and over, starting from zero. Each result overwrites the next pair of table words, first the subkeys and then the four tables in turn.

The block uses one `ready` handshake for both key setup and single-block encryption or decryption. While `ready` is low, every strobe is ignored. When `ready` rises after a block operation, `data_out` holds the result.

Top module: `bfk_keysched_top`

## Requirements
- R1: After reset, `ready` is high and `data_out` is zero.
- R2: The effective key length n equals `key_len` for values 1 to 14, and values 0 and 15 both select n = 14. Key word j is `key[447-32j -: 32]`, so word 0 is the most significant 32 bits. Subkey i is XORed with key word (i mod n).
- R3: Key setup encrypts a 64-bit running value that starts at zero. Result w is written to linear table words 2w and 2w+1, with the upper half at the lower address. Linear words 0..17 are the subkeys, and word 18+t·D+e is entry e of table t, where D = 2^IDX_W. When `ready` returns, `data_out` holds the last running value.
- R4: `ready` goes low on the edge that accepts `new_key` and goes high again exactly 18 + 18·(9 + 2D) clock edges later. With IDX_W = 4 this is 756 edges.
- R5: `new_data` with `encrypt`=1 encrypts `data_in` and with `encrypt`=0 decrypts it. The operation runs 16 rounds using the round function ((T0[a]+T1[b]) xor T2[c]) + T3[d], where a, b, c and d are the low IDX_W bits of the bytes of the round input, most significant byte first. Decryption uses the subkeys in reverse order. The result appears on `data_out` with `ready` exactly 17 edges after acceptance.
- R6: `new_key`, `new_data` and `cfg_we` have no effect while `ready` is low.
- R7: If `new_key` and `new_data` are high in the same accepted cycle, the key setup runs and the data strobe is dropped.
- R8: While `ready` is high and no strobe is accepted, `cfg_we` writes `cfg_wdata` to linear table word `cfg_addr`, using the layout in R3.
- R9: While `ready` stays high, `data_out` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key | input | 448 | Key, zero-padded at the low end |
| key_len | input | 4 | Key length in 32-bit words |
| new_key | input | 1 | Start key setup |
| new_data | input | 1 | Start a block operation |
| encrypt | input | 1 | 1 encrypt, 0 decrypt |
| data_in | input | 64 | Block input |
| cfg_we | input | 1 | Table preload write strobe |
| cfg_addr | input | ADDR_W | Linear table word address |
| cfg_wdata | input | 32 | Preload word |
| ready | output | 1 | Idle and accepting strobes |
| data_out | output | 64 | Block result or final running value |

## Verification
The hardest cases to reach from the ports are strobes that arrive in the middle of a key setup. A stray preload write or a second command there would silently corrupt tables that are only seen later, through encryption results. The stimulus fires `new_key`, `new_data` and a preload write together at a fixed point deep inside one setup, and raises `new_key` during a block operation. Two things then show that nothing was touched: the latency count, and encrypt and decrypt results compared against a behavioural model. Runs with key lengths 0 and 15 are compared against the 14-word model.

// File: rtl/bfk_pkg.sv
package bfk_pkg;
    localparam int NP        = 18;
    localparam int ROUNDS    = 16;
    localparam int KEY_BITS  = 448;
    localparam int MAX_WORDS = 14;

    typedef logic [31:0] word_t;
    typedef logic [63:0] block_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MIX,
        ST_LAUNCH,
        ST_KWAIT,
        ST_DWAIT
    } seq_state_e;

    function automatic logic [3:0] eff_len(input logic [3:0] l);
        return (l == 4'd0 || l == 4'd15) ? 4'd14 : l;
    endfunction

    function automatic int addr_w(input int idx_w);
        return $clog2(NP + 4 * (1 << idx_w));
    endfunction
endpackage

// File: rtl/bfk_tables.sv
module bfk_tables
    import bfk_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam int D  = 1 << IDX_W,
    localparam int AW = addr_w(IDX_W)
) (
    input  logic             clk,
    input  logic             wa_en,
    input  logic [AW-1:0]    wa_addr,
    input  word_t            wa_data,
    input  logic             wb_en,
    input  logic [AW-1:0]    wb_addr,
    input  word_t            wb_data,
    input  logic [IDX_W-1:0] sidx [4],
    output word_t            sval [4],
    output word_t            p_q  [NP]
);
    word_t p_mem [NP];

    // Offsets of each write into the table region
    logic [AW-1:0] off_a, off_b;
    logic          a_tab, b_tab;

    always_comb begin
        off_a = wa_addr - AW'(NP);
        off_b = wb_addr - AW'(NP);
        a_tab = wa_en && (wa_addr >= AW'(NP)) && (off_a < AW'(4 * D));
        b_tab = wb_en && (wb_addr >= AW'(NP)) && (off_b < AW'(4 * D));
    end

    always_ff @(posedge clk) begin
        if (wa_en && wa_addr < AW'(NP)) p_mem[wa_addr[4:0]] <= wa_data;
        if (wb_en && wb_addr < AW'(NP)) p_mem[wb_addr[4:0]] <= wb_data;
    end

    for (genvar i = 0; i < NP; i++) begin : g_pout
        assign p_q[i] = p_mem[i];
    end

    for (genvar t = 0; t < 4; t++) begin : g_tab
        word_t s_mem [D];
        always_ff @(posedge clk) begin
            if (a_tab && off_a[IDX_W +: 2] == 2'(t)) s_mem[off_a[IDX_W-1:0]] <= wa_data;
            if (b_tab && off_b[IDX_W +: 2] == 2'(t)) s_mem[off_b[IDX_W-1:0]] <= wb_data;
        end
        assign sval[t] = s_mem[sidx[t]];
    end
endmodule

// File: rtl/bfk_round_engine.sv
module bfk_round_engine
    import bfk_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             enc,
    input  block_t           din,
    input  word_t            p_q  [NP],
    input  word_t            sval [4],
    output logic [IDX_W-1:0] sidx [4],
    output logic             busy,
    output logic             done,
    output block_t           result
);
    word_t      l_q, r_q;
    logic [3:0] rnd;
    logic       mode_enc;

    logic [4:0] k;
    word_t      t, f, nl, nr, pa, pb;

    always_comb begin
        k  = mode_enc ? {1'b0, rnd} : 5'd17 - {1'b0, rnd};
        t  = l_q ^ p_q[k];
        f  = ((sval[0] + sval[1]) ^ sval[2]) + sval[3];
        nl = r_q ^ f;
        nr = t;
        pa = mode_enc ? p_q[16] : p_q[1];
        pb = mode_enc ? p_q[17] : p_q[0];
    end

    for (genvar j = 0; j < 4; j++) begin : g_idx
        assign sidx[j] = t[(24 - 8 * j) +: IDX_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l_q      <= '0;
            r_q      <= '0;
            rnd      <= '0;
            mode_enc <= 1'b1;
            busy     <= 1'b0;
            done     <= 1'b0;
            result   <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                l_q      <= din[63:32];
                r_q      <= din[31:0];
                rnd      <= '0;
                mode_enc <= enc;
                busy     <= 1'b1;
            end else if (busy) begin
                l_q <= nl;
                r_q <= nr;
                rnd <= rnd + 4'd1;
                if (rnd == 4'(ROUNDS - 1)) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    result <= {nr ^ pb, nl ^ pa};
                end
            end
        end
    end
endmodule

// File: rtl/bfk_key_sched.sv
module bfk_key_sched
    import bfk_pkg::*;
#(
    parameter int IDX_W       = 8,
    parameter int FIXED_WORDS = 0,
    localparam int D   = 1 << IDX_W,
    localparam int TOT = NP + 4 * D,
    localparam int AW  = addr_w(IDX_W),
    localparam int NE  = TOT / 2,
    localparam int PW  = $clog2(NE)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [KEY_BITS-1:0] key,
    input  logic [3:0]          key_len,
    input  logic                new_key,
    input  logic                new_data,
    input  logic                encrypt,
    input  block_t              data_in,
    input  logic                cfg_we,
    input  logic [AW-1:0]       cfg_addr,
    input  word_t               cfg_wdata,
    input  word_t               p_q [NP],
    input  logic                eng_done,
    input  block_t              eng_result,
    output logic                eng_start,
    output logic                eng_enc,
    output block_t              eng_din,
    output logic                wa_en,
    output logic [AW-1:0]       wa_addr,
    output word_t               wa_data,
    output logic                wb_en,
    output logic [AW-1:0]       wb_addr,
    output word_t               wb_data,
    output logic                ready,
    output block_t              data_out
);
    seq_state_e    state;
    logic [4:0]    idx;
    logic [3:0]    kidx;
    logic [PW-1:0] pair;
    block_t        chain;
    logic [3:0]    nwords;
    word_t         kwords [MAX_WORDS];
    word_t         kw;
    logic [AW-1:0] base;

    // Key length: run-time decode or constant wiring
    if (FIXED_WORDS == 0) begin : g_var_len
        assign nwords = eff_len(key_len);
    end else begin : g_fix_len
        assign nwords = 4'(FIXED_WORDS);
    end

    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_kw
        assign kwords[g] = key[KEY_BITS - 1 - 32 * g -: 32];
    end

    assign kw    = kwords[kidx];
    assign base  = AW'({pair, 1'b0});
    assign ready = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            idx      <= '0;
            kidx     <= '0;
            pair     <= '0;
            chain    <= '0;
            data_out <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (new_key) begin
                        state <= ST_MIX;
                        idx   <= '0;
                        kidx  <= '0;
                        pair  <= '0;
                        chain <= '0;
                    end else if (new_data) begin
                        state <= ST_DWAIT;
                    end
                end
                ST_MIX: begin
                    idx  <= idx + 5'd1;
                    kidx <= (kidx == 4'(nwords - 4'd1)) ? 4'd0 : kidx + 4'd1;
                    if (idx == 5'(NP - 1)) state <= ST_LAUNCH;
                end
                ST_LAUNCH: state <= ST_KWAIT;
                ST_KWAIT: begin
                    if (eng_done) begin
                        chain    <= eng_result;
                        data_out <= eng_result;
                        pair     <= pair + PW'(1);
                        state    <= (pair == PW'(NE - 1)) ? ST_IDLE : ST_LAUNCH;
                    end
                end
                ST_DWAIT: begin
                    if (eng_done) begin
                        data_out <= eng_result;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        eng_start = 1'b0;
        eng_enc   = 1'b1;
        eng_din   = chain;
        wa_en     = 1'b0;
        wa_addr   = '0;
        wa_data   = '0;
        wb_en     = 1'b0;
        wb_addr   = '0;
        wb_data   = '0;
        case (state)
            ST_IDLE: begin
                if (!new_key && new_data) begin
                    eng_start = 1'b1;
                    eng_enc   = encrypt;
                    eng_din   = data_in;
                end else if (!new_key && cfg_we) begin
                    wa_en   = 1'b1;
                    wa_addr = cfg_addr;
                    wa_data = cfg_wdata;
                end
            end
            ST_MIX: begin
                wa_en   = 1'b1;
                wa_addr = AW'(idx);
                wa_data = p_q[idx] ^ kw;
            end
            ST_LAUNCH: eng_start = 1'b1;
            ST_KWAIT: begin
                if (eng_done) begin
                    wa_en   = 1'b1;
                    wa_addr = base;
                    wa_data = eng_result[63:32];
                    wb_en   = 1'b1;
                    wb_addr = base + AW'(1);
                    wb_data = eng_result[31:0];
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bfk_keysched_top.sv
module bfk_keysched_top
    import bfk_pkg::*;
#(
    parameter int IDX_W       = 8,
    parameter int FIXED_WORDS = 0,
    localparam int AW = addr_w(IDX_W)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [447:0]   key,
    input  logic [3:0]     key_len,
    input  logic           new_key,
    input  logic           new_data,
    input  logic           encrypt,
    input  logic [63:0]    data_in,
    input  logic           cfg_we,
    input  logic [AW-1:0]  cfg_addr,
    input  logic [31:0]    cfg_wdata,
    output logic           ready,
    output logic [63:0]    data_out
);
    word_t            p_q  [NP];
    word_t            sval [4];
    logic [IDX_W-1:0] sidx [4];
    logic             eng_start, eng_enc, eng_busy, eng_done;
    block_t           eng_din, eng_result;
    logic             wa_en, wb_en;
    logic [AW-1:0]    wa_addr, wb_addr;
    word_t            wa_data, wb_data;

    bfk_key_sched #(.IDX_W(IDX_W), .FIXED_WORDS(FIXED_WORDS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .key        (key),
        .key_len    (key_len),
        .new_key    (new_key),
        .new_data   (new_data),
        .encrypt    (encrypt),
        .data_in    (data_in),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .p_q        (p_q),
        .eng_done   (eng_done),
        .eng_result (eng_result),
        .eng_start  (eng_start),
        .eng_enc    (eng_enc),
        .eng_din    (eng_din),
        .wa_en      (wa_en),
        .wa_addr    (wa_addr),
        .wa_data    (wa_data),
        .wb_en      (wb_en),
        .wb_addr    (wb_addr),
        .wb_data    (wb_data),
        .ready      (ready),
        .data_out   (data_out)
    );

    bfk_round_engine #(.IDX_W(IDX_W)) u_eng (
        .clk    (clk),
        .rst    (rst),
        .start  (eng_start),
        .enc    (eng_enc),
        .din    (eng_din),
        .p_q    (p_q),
        .sval   (sval),
        .sidx   (sidx),
        .busy   (eng_busy),
        .done   (eng_done),
        .result (eng_result)
    );

    bfk_tables #(.IDX_W(IDX_W)) u_tab (
        .clk     (clk),
        .wa_en   (wa_en),
        .wa_addr (wa_addr),
        .wa_data (wa_data),
        .wb_en   (wb_en),
        .wb_addr (wb_addr),
        .wb_data (wb_data),
        .sidx    (sidx),
        .sval    (sval),
        .p_q     (p_q)
    );
endmodule

// File: rtl/bfk_chk.sv
module bfk_chk (
    input logic        clk,
    input logic        rst,
    input logic        new_key,
    input logic        new_data,
    input logic        ready,
    input logic [63:0] data_out,
    input logic        eng_start,
    input logic        eng_busy,
    input logic        eng_done
);
    // R1
    reset_ready_chk: assert property (@(posedge clk) $past(rst) |-> ready && data_out == 64'd0);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ready && !new_key && !new_data |=> ready && $stable(data_out));

    // R4
    key_accept_chk: assert property (@(posedge clk) disable iff (rst)
        ready && new_key |=> !ready);

    // R5
    data_accept_chk: assert property (@(posedge clk) disable iff (rst)
        ready && new_data |=> !ready);

    // R6
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !eng_busy);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> !eng_done);
endmodule

bind bfk_keysched_top bfk_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .new_key   (new_key),
    .new_data  (new_data),
    .ready     (ready),
    .data_out  (data_out),
    .eng_start (eng_start),
    .eng_busy  (eng_busy),
    .eng_done  (eng_done)
);

// File: tb/tb_bfk_keysched_top.sv
module tb_bfk_keysched_top;
    import bfk_pkg::*;

    localparam int IDX_W = 4;
    localparam int D     = 1 << IDX_W;
    localparam int TOT   = NP + 4 * D;
    localparam int AW    = addr_w(IDX_W);
    localparam int NE    = TOT / 2;
    localparam int SETUP = 18 + 18 * NE;
    localparam int DLAT  = 17;

    logic          clk = 1'b0;
    logic          rst;
    logic [447:0]  key;
    logic [3:0]    key_len;
    logic          new_key, new_data, encrypt, cfg_we;
    logic [63:0]   data_in;
    logic [AW-1:0] cfg_addr;
    logic [31:0]   cfg_wdata;
    logic          ready;
    logic [63:0]   data_out;

    always #2.5 clk = ~clk;

    bfk_keysched_top #(.IDX_W(IDX_W)) dut (
        .clk(clk), .rst(rst), .key(key), .key_len(key_len),
        .new_key(new_key), .new_data(new_data), .encrypt(encrypt),
        .data_in(data_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ready(ready), .data_out(data_out)
    );

    int     errors = 0;
    int     checks = 0;
    word_t  ip [NP];
    word_t  is [4][D];
    word_t  mp [NP];
    word_t  ms [4][D];
    block_t mchain;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic word_t mf(input word_t t);
        return ((ms[0][t[24 +: IDX_W]] + ms[1][t[16 +: IDX_W]]) ^ ms[2][t[8 +: IDX_W]])
               + ms[3][t[0 +: IDX_W]];
    endfunction

    function automatic block_t mcrypt(input block_t b, input bit enc);
        word_t l = b[63:32];
        word_t r = b[31:0];
        for (int i = 0; i < 16; i++) begin
            word_t t = l ^ mp[enc ? i : 17 - i];
            l = r ^ mf(t);
            r = t;
        end
        return enc ? {r ^ mp[17], l ^ mp[16]} : {r ^ mp[0], l ^ mp[1]};
    endfunction

    task automatic mput(input int a, input word_t v);
        if (a < NP) mp[a] = v;
        else ms[(a - NP) / D][(a - NP) % D] = v;
    endtask

    task automatic model_setup(input logic [447:0] k, input int n);
        for (int i = 0; i < NP; i++) mp[i] = mp[i] ^ k[447 - 32 * (i % n) -: 32];
        mchain = '0;
        for (int w = 0; w < NE; w++) begin
            mchain = mcrypt(mchain, 1'b1);
            mput(2 * w, mchain[63:32]);
            mput(2 * w + 1, mchain[31:0]);
        end
    endtask

    // R8: preload every table word through the port
    task automatic load_tables();
        for (int a = 0; a < TOT; a++) begin
            @(negedge clk);
            cfg_we    = 1'b1;
            cfg_addr  = AW'(a);
            cfg_wdata = (a < NP) ? ip[a] : is[(a - NP) / D][(a - NP) % D];
        end
        @(negedge clk);
        cfg_we = 1'b0;
        for (int i = 0; i < NP; i++) mp[i] = ip[i];
        for (int t = 0; t < 4; t++)
            for (int e = 0; e < D; e++) ms[t][e] = is[t][e];
    endtask

    task automatic do_setup(input logic [447:0] k, input logic [3:0] len, input int n_exp,
                            input bit disturb, input bit both);
        int cnt = 0;
        load_tables();
        @(negedge clk);
        key = k; key_len = len; new_key = 1'b1; new_data = both;
        data_in = {$urandom, $urandom};
        @(posedge clk);
        while (cnt < 20000) begin
            @(negedge clk);
            new_key = 1'b0; new_data = 1'b0; cfg_we = 1'b0;
            if (ready) break;
            if (disturb && cnt == 100) begin
                // R6: strobes in mid-setup must be dropped
                new_key = 1'b1; new_data = 1'b1; cfg_we = 1'b1;
                cfg_addr = '0; cfg_wdata = 32'hdead_beef;
            end
            @(posedge clk);
            cnt++;
        end
        model_setup(k, n_exp);
        chk(both ? "R7 setup latency" : "R4 setup latency", 64'(cnt), 64'(SETUP));
        chk("R3 final running value", data_out, mchain);
    endtask

    task automatic run_block(input bit enc, input block_t din, input bit poke,
                             output block_t dout);
        int cnt = 0;
        @(negedge clk);
        new_data = 1'b1; encrypt = enc; data_in = din;
        @(posedge clk);
        while (cnt < 200) begin
            @(negedge clk);
            new_data = 1'b0; new_key = 1'b0;
            if (ready) break;
            if (poke && cnt == 5) new_key = 1'b1;
            @(posedge clk);
            cnt++;
        end
        chk(poke ? "R6 block latency" : "R5 block latency", 64'(cnt), 64'(DLAT));
        dout = data_out;
    endtask

    task automatic blocks(input int nblk, input bit poke);
        for (int b = 0; b < nblk; b++) begin
            block_t pt = {$urandom, $urandom};
            block_t ct, back;
            run_block(1'b1, pt, poke && b == 0, ct);
            chk("R5 encrypt", ct, mcrypt(pt, 1'b1));
            run_block(1'b0, ct, 1'b0, back);
            chk("R5 decrypt round trip", back, pt);
        end
    endtask

    function automatic logic [447:0] make_key(input int n);
        logic [447:0] k = '0;
        for (int j = 0; j < n; j++) k[447 - 32 * j -: 32] = $urandom;
        return k;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R4 watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        block_t hold;
        void'($urandom(32'h0bf5_1a2c));
        rst = 1'b1; key = '0; key_len = 4'd4; new_key = 1'b0; new_data = 1'b0;
        encrypt = 1'b1; data_in = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        for (int i = 0; i < NP; i++) ip[i] = $urandom;
        for (int t = 0; t < 4; t++)
            for (int e = 0; e < D; e++) is[t][e] = $urandom;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", 64'(ready), 64'd1);
        chk("R1 data_out after reset", data_out, 64'd0);

        // R2: lengths 4, 1, 14 and the fallbacks 0 and 15
        do_setup(make_key(4), 4'd4, 4, 1'b0, 1'b0);
        blocks(2, 1'b0);
        do_setup(make_key(1), 4'd1, 1, 1'b0, 1'b0);
        blocks(1, 1'b0);
        do_setup(make_key(14), 4'd14, 14, 1'b0, 1'b0);
        blocks(1, 1'b0);
        do_setup(make_key(14), 4'd0, 14, 1'b0, 1'b0);
        blocks(1, 1'b0);
        do_setup(make_key(14), 4'd15, 14, 1'b0, 1'b0);
        blocks(1, 1'b0);

        // R6: strobes during setup and during a block
        do_setup(make_key(9), 4'd9, 9, 1'b1, 1'b0);
        blocks(2, 1'b1);

        // R7: both strobes together, key wins
        do_setup(make_key(6), 4'd6, 6, 1'b0, 1'b1);
        blocks(1, 1'b0);

        // R9: idle with changing data_in
        hold = data_out;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            data_in = {$urandom, $urandom};
            encrypt = ~encrypt;
        end
        @(negedge clk);
        chk("R9 data_out held while idle", data_out, hold);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule